// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Receive Queue

This block recovers asynchronous serial characters from a single input line. A pulse at sixteen times the bit rate steps the bit timing. The character format is set at run time by configuration pins: word length, parity mode and one or two stop bits. The line first passes through a small synchronizer. A state machine then finds each start bit, checks it, and samples every later bit at the middle of its bit period.

Each recovered character goes into a 16-entry queue as a 12-bit word. The word holds the data byte and four error flags for that character: framing, parity, break and overrun. The host sees the oldest word at all times, removes it with a pop strobe, and watches empty and full status. An enable pin starts and stops capture. Words already queued stay readable while capture is off.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the queue reports empty (`fifo_empty_o`=1) and not full (`fifo_full_o`=0).
- R2: A stored word puts the data in bits 7:0, the framing flag in bit 8, the parity flag in bit 9, the break flag in bit 10 and the overrun flag in bit 11.
- R3: `cfg_wlen_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data bits arrive least significant first, and unused upper data bits are stored as zero.
- R4: With `cfg_par_en_i`=1, a parity bit follows the data. With `cfg_par_stick_i`=0, `cfg_par_even_i`=0 expects odd parity and `cfg_par_even_i`=1 expects even parity. With `cfg_par_stick_i`=1, `cfg_par_even_i`=0 expects a constant 1 and `cfg_par_even_i`=1 expects a constant 0. A mismatch sets bit 9.
- R5: `cfg_two_stop_i` selects one (0) or two (1) stop bits. Bit 8 is set only when the first stop bit is sampled low. The level of a second stop bit has no effect on the stored word.
- R6: A falling edge becomes a start bit only if the line is still low at the mid-bit sample, 8 ticks later. A shorter low pulse stores nothing.
- R7: A frame that is all zeros (start, data, any parity bit and the first stop bit) is stored once as word 0x500: break and framing set, parity clear, data zero. The receiver then waits for the line to go high, so a held-low line stores only that one word.
- R8: The queue holds 16 words and returns them in arrival order. `fifo_full_o` is 1 exactly when 16 words are held, and `fifo_empty_o` is 1 exactly when none are held.
- R9: A character that completes while the queue is full is discarded. Bit 11 is then set on the most recently stored word.
- R10: While `enable_i`=0 no character is stored, and queued words can still be read and popped.
- R11: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Capture enable |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idles high |
| cfg_wlen_i | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_even_i | input | 1 | Even (or constant-0) parity select |
| cfg_par_stick_i | input | 1 | Constant-parity select |
| cfg_two_stop_i | input | 1 | Two stop bits |
| pop_i | input | 1 | Remove the oldest word |
| rd_word_o | output | 12 | Oldest queued word |
| fifo_empty_o | output | 1 | Queue empty |
| fifo_full_o | output | 1 | Queue full |

## Verification
The bench sweeps every word length against all five parity settings and both stop counts. A design that picked the wrong parity sense, kept stale upper bits or mis-timed the mid-bit sample would store wrong data or wrong flags for some of these formats. It then covers the corner cases one by one:
- A line held low for many bit times must give exactly one break word. A design that did not wait for the line to go high would fill the queue with repeated zero words.
- A seventeenth character into a full queue must flag the sixteenth word and must not overwrite it.
- A short low glitch must store nothing.
- A low second stop bit must not raise the framing flag.
- A pop on an empty queue must not corrupt the pointers.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par_err;
    logic       frm_err;
    logic [7:0] data;
  } rx_word_t;

  typedef enum logic [2:0] {
    ST_WAIT_HIGH,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic       two_stop_i,
  output logic       push_o,
  output rx_word_t   word_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  rx_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [2:0]     bit_q, bit_d;
  logic [7:0]     shift_q, shift_d;
  logic           par_q, par_d;
  logic           frm_q, frm_d;
  logic           push_d;
  rx_word_t       word_d;

  logic [2:0]     last_bit;
  logic           bit_end;
  logic           frm_now;
  logic           brk_now;
  logic           exp_par;
  logic           finish;

  assign last_bit = 3'(data_len(wlen_i) - 4'd1);
  assign bit_end  = tick_i && (cnt_q == LAST_C);
  assign frm_now  = (state_q == ST_STOP1) ? !line_i : frm_q;
  assign brk_now  = frm_now && (shift_q == 8'h00) && (!par_en_i || !par_q);

  always_comb begin
    if (par_stick_i)     exp_par = !par_even_i;
    else if (par_even_i) exp_par = ^shift_q;
    else                 exp_par = ~^shift_q;
  end

  always_comb begin
    word_d.ovr     = 1'b0;
    word_d.brk     = brk_now;
    word_d.par_err = par_en_i && !brk_now && (par_q != exp_par);
    word_d.frm_err = frm_now;
    word_d.data    = shift_q;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    par_d   = par_q;
    frm_d   = frm_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_WAIT_HIGH: begin
        if (line_i) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (tick_i && !line_i) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == MID_C) begin
            cnt_d = '0;
            if (!line_i) begin
              state_d = ST_DATA;
              bit_d   = '0;
              shift_d = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          cnt_d          = '0;
          shift_d[bit_q] = line_i;
          if (bit_q == last_bit) state_d = par_en_i ? ST_PARITY : ST_STOP1;
          else                   bit_d   = bit_q + 1'b1;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PARITY: begin
        if (bit_end) begin
          cnt_d   = '0;
          par_d   = line_i;
          state_d = ST_STOP1;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP1: begin
        if (bit_end) begin
          cnt_d = '0;
          frm_d = !line_i;
          if (two_stop_i) state_d = ST_STOP2;
          else            finish  = 1'b1;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP2: begin
        if (bit_end) begin
          cnt_d  = '0;
          finish = 1'b1;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_WAIT_HIGH;
    endcase
    if (finish) state_d = ST_WAIT_HIGH;
    push_d = finish && enable_i;
    if (!enable_i) begin
      state_d = ST_WAIT_HIGH;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_HIGH;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      frm_q   <= 1'b0;
      push_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      par_q   <= par_d;
      frm_q   <= frm_d;
      push_o  <= push_d;
      if (push_d) word_o <= word_d;
    end
  end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] word_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wptr_q, wptr_d;
  logic [AW:0]  rptr_q, rptr_d;
  logic         pop_ok, push_ok, ovr_hit;
  logic [AW-1:0] last_idx;

  assign empty_o  = (wptr_q == rptr_q);
  assign full_o   = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign pop_ok   = pop_i && !empty_o;
  assign push_ok  = push_i && (!full_o || pop_ok);
  assign ovr_hit  = push_i && full_o && !pop_ok;
  assign last_idx = wptr_q[AW-1:0] - 1'b1;
  assign head_o   = mem_q[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push_ok) wptr_d = wptr_q + 1'b1;
    if (pop_ok)  rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok)      mem_q[wptr_q[AW-1:0]]  <= word_i;
    else if (ovr_hit) mem_q[last_idx][W-1]   <= 1'b1;
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        tick16_i,
  input  logic        rxd_i,
  input  logic [1:0]  cfg_wlen_i,
  input  logic        cfg_par_en_i,
  input  logic        cfg_par_even_i,
  input  logic        cfg_par_stick_i,
  input  logic        cfg_two_stop_i,
  input  logic        pop_i,
  output logic [11:0] rd_word_o,
  output logic        fifo_empty_o,
  output logic        fifo_full_o
);
  localparam int WW = $bits(rx_word_t);

  logic [1:0]  rst_sync_q;
  logic        rst_n_int;
  logic        line_s;
  logic        frame_push;
  rx_word_t    frame_word_s;
  logic [WW-1:0] frame_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (rxd_i),
    .q_o    (line_s)
  );

  rx_deframer #(.OSR(OSR)) deframer_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .enable_i    (enable_i),
    .tick_i      (tick16_i),
    .line_i      (line_s),
    .wlen_i      (cfg_wlen_i),
    .par_en_i    (cfg_par_en_i),
    .par_even_i  (cfg_par_even_i),
    .par_stick_i (cfg_par_stick_i),
    .two_stop_i  (cfg_two_stop_i),
    .push_o      (frame_push),
    .word_o      (frame_word_s)
  );

  assign frame_word = frame_word_s;

  rx_tag_fifo #(.DEPTH(DEPTH), .W(WW)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .push_i  (frame_push),
    .word_i  (frame_word),
    .pop_i   (pop_i),
    .head_o  (rd_word_o),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full_o)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        pop_i,
  input logic        empty_i,
  input logic        full_i,
  input logic        push_i,
  input logic [11:0] word_i,
  input logic [1:0]  wlen_i
);
  logic [3:0] nbits;
  assign nbits = 4'd5 + {2'b00, wlen_i};

  // R8: empty and full never together
  p_status_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_i && full_i));

  // R3: unused upper data bits are zero in a pushed word
  p_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ((word_i[7:0] >> nbits) == 8'h00));

  // R7: a break word carries zero data, framing set, parity clear
  p_break_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && word_i[10]) |-> (word_i[7:0] == 8'h00 && word_i[8] && !word_i[9]));

  // R11: an empty queue stays empty without a push, pop or not
  p_empty_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && !push_i) |=> empty_i);

  // R9: a full queue stays full until popped
  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !pop_i) |=> full_i);

  // R10: no push follows a disabled cycle
  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !push_i);
endmodule

bind serial_rx_core serial_rx_checker chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .pop_i    (pop_i),
  .empty_i  (fifo_empty_o),
  .full_i   (fifo_full_o),
  .push_i   (frame_push),
  .word_i   (frame_word),
  .wlen_i   (cfg_wlen_i)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic        rxd = 1'b1;
  logic [1:0]  wlen = 2'd3;
  logic        par_en = 1'b0;
  logic        par_even = 1'b0;
  logic        par_stick = 1'b0;
  logic        two_stop = 1'b0;
  logic        pop = 1'b0;
  logic [11:0] rd_word;
  logic        empty, full;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam int BIT_CLKS = 32;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  serial_rx_core dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .enable_i        (enable),
    .tick16_i        (tick),
    .rxd_i           (rxd),
    .cfg_wlen_i      (wlen),
    .cfg_par_en_i    (par_en),
    .cfg_par_even_i  (par_even),
    .cfg_par_stick_i (par_stick),
    .cfg_two_stop_i  (two_stop),
    .pop_i           (pop),
    .rd_word_o       (rd_word),
    .fifo_empty_o    (empty),
    .fifo_full_o     (full)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic set_cfg(input int wl, input int mode, input logic two);
    wlen      = 2'(wl);
    par_en    = (mode != 0);
    par_even  = (mode == 2) || (mode == 4);
    par_stick = (mode >= 3);
    two_stop  = two;
  endtask

  function automatic logic par_bit(input logic [7:0] d, input int mode);
    int ones = $countones(d);
    case (mode)
      1: return (ones % 2 == 0);
      2: return (ones % 2 == 1);
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                            input logic pbit, input logic two,
                            input logic s1, input logic s2);
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pen) send_bit(pbit);
    send_bit(s1);
    if (two) send_bit(s2);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic expect_pop(input string req, input logic [11:0] exp);
    chk(req, {11'b0, empty}, 12'h000);
    chk(req, rd_word, exp);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 empty", {11'b0, empty}, 12'h001);
    chk("R1 full",  {11'b0, full},  12'h000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 empty after release", {11'b0, empty}, 12'h001);
    enable = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5: sweep over formats
    for (int wl = 0; wl < 4; wl++) begin
      for (int mode = 0; mode < 5; mode++) begin
        for (int st = 0; st < 2; st++) begin
          for (int k = 0; k < 3; k++) begin
            logic [7:0] d, dm;
            int nb;
            nb = wl + 5;
            d  = (k == 0) ? 8'hA5 : (k == 1) ? (8'h3C ^ 8'(wl * 17 + mode)) : 8'hFF;
            dm = d & 8'((1 << nb) - 1);
            set_cfg(wl, mode, st[0]);
            send_frame(d, nb, mode != 0, par_bit(dm, mode), st[0], 1'b1, 1'b1);
            expect_pop("R3 R4 R5 sweep", {4'b0, dm});
          end
        end
      end
    end

    // R4: parity mismatch, odd, 8 bits
    set_cfg(3, 1, 1'b0);
    send_frame(8'h33, 8, 1'b1, ~par_bit(8'h33, 1), 1'b0, 1'b1, 1'b1);
    expect_pop("R4 parity error flag bit 9", 12'h233);
    // R4: mark expected, space sent
    set_cfg(2, 3, 1'b0);
    send_frame(8'h15, 7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_pop("R4 mark mismatch", 12'h215);

    // R5: framing error on low first stop
    set_cfg(3, 0, 1'b0);
    send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_pop("R5 framing flag bit 8", 12'h15A);
    // R5: low second stop ignored
    set_cfg(3, 0, 1'b1);
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_pop("R5 second stop ignored", 12'h0C3);

    // R6: short glitch stores nothing
    set_cfg(3, 0, 1'b0);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R6 glitch ignored", {11'b0, empty}, 12'h001);

    // R7: long break gives one word
    set_cfg(3, 2, 1'b0);
    rxd = 1'b0;
    repeat (14 * BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    expect_pop("R7 break word", 12'h500);
    chk("R7 single break word", {11'b0, empty}, 12'h001);

    // R11: pop on empty, then normal traffic intact
    set_cfg(3, 0, 1'b0);
    pop = 1'b1;
    repeat (3) @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
    chk("R11 still empty", {11'b0, empty}, 12'h001);
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_pop("R11 data after empty pop", 12'h081);
    chk("R11 empty again", {11'b0, empty}, 12'h001);

    // R8 R9: fill, overrun, drain in order
    for (int i = 0; i < 17; i++) begin
      send_frame(8'(i + 1), 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      if (i == 14) chk("R8 not full at 15", {11'b0, full}, 12'h000);
      if (i == 15) chk("R8 full at 16", {11'b0, full}, 12'h001);
    end
    chk("R9 full after overrun", {11'b0, full}, 12'h001);
    for (int i = 0; i < 16; i++) begin
      logic [11:0] e;
      e = {4'b0, 8'(i + 1)};
      if (i == 15) e = e | 12'h800;
      expect_pop("R8 R9 drain order and overrun flag", e);
    end
    chk("R8 empty after drain", {11'b0, empty}, 12'h001);

    // R10: disabled capture, queue still readable
    send_frame(8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    enable = 1'b0;
    @(negedge clk);
    send_frame(8'h99, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_pop("R10 readable while disabled", 12'h042);
    chk("R10 nothing captured", {11'b0, empty}, 12'h001);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(8'h17, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_pop("R10 capture resumes", 12'h017);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule